// File: doc/BRIEF.md
# Dual-Port Two-Wire Serial Memory Slave

This block puts two independent two-wire (I2C-style) slave front ends in front of one shared 512-byte memory. One port faces a display link and is restricted. The other port faces a host controller and can reach the whole array. Each port oversamples its clock and data lines in the system clock domain and finds START and STOP conditions. It then receives a control byte. The control byte has a 4-bit device type code (binary 1010), three block-select bits and a direction bit. After that the port writes data to, or reads data from, the memory at an internal word address.

The data line is modelled as open drain. Each port reads the resolved line level on its data input and pulls the line low through a separate pull output. When one port writes a data byte and the transaction then closes with STOP, a programming cycle starts. The programming cycle is shared by both ports, and neither port acknowledges any byte while it runs. A status pin shows the programming cycle, and another pin shows when both ports are in a transaction at the same time. Neither port has any back-pressure path: the bus master sets the pace, and every memory access fits inside one bus bit time.

Top module: `dual_i2c_mem`

## Requirements
- R1: A falling data line while the clock line is high is a START. A rising data line while the clock is high is a STOP. A START at any point, including in the middle of a byte, clears the bit count and restarts reception of a control byte.
- R2: The first byte after a START is the control byte, sent MSB first. Bits 7:4 must equal 1010 or the port does not acknowledge. After a refused byte the port ignores the bus until the next START or STOP.
- R3: The display port acknowledges a control byte only when select bits 3:1 are all zero. It always works in the lower 256-byte block.
- R4: The host port ignores control bits 3 and 2. Control bit 1 becomes bit 8 of the word address and so picks the 256-byte block.
- R5: The port acknowledges a received byte by pulling the data line low. The pull begins on the clock fall after the eighth bit, holds for the whole high phase of the ninth clock, and ends on the next clock fall.
- R6: Control bit 0 set to 0 selects a write. The next byte sets the low 8 bits of the word address. Each further byte is stored at the word address. The address then steps by one and wraps inside its 256-byte block.
- R7: Control bit 0 set to 1 selects a read. Bytes come out MSB first, starting at the current word address. The address steps by one after each byte and wraps inside its block.
- R8: If the master does not acknowledge a read byte, the port releases the data line and drives nothing more until the next START or STOP.
- R9: A STOP that ends a transaction in which at least one data byte was stored raises `prog_busy` for PROG_CYCLES clocks. While `prog_busy` is high, neither port acknowledges any byte.
- R10: The two ports run independently and at the same time. `both_active` is high exactly while both ports are between a START and a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_scl | input | 1 | Display port clock line |
| disp_sda_in | input | 1 | Display port resolved data line level |
| disp_sda_pull | output | 1 | Display port data pull-low enable |
| host_scl | input | 1 | Host port clock line |
| host_sda_in | input | 1 | Host port resolved data line level |
| host_sda_pull | output | 1 | Host port data pull-low enable |
| prog_busy | output | 1 | Programming cycle in progress |
| both_active | output | 1 | Both ports inside a transaction |

## Verification
The bench keeps BLK_W at 8, so the 256-byte block wrap from address 0xFF back to 0x00 can be reached with two-byte transfers in both blocks. It lowers PROG_CYCLES to 400 clocks. At that value, a control byte sent right after a STOP still lands inside the programming window and is refused, and the run can then wait out the window and read the data back. The bus quarter-bit is five system clocks, which leaves room for the synchronizer delay before each sample.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_CTRL,
    PS_ADDR,
    PS_WR,
    PS_RD,
    PS_SKIP
  } port_st_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2cm_edge.sv
module i2cm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cm_port.sv
module i2cm_port import i2cm_pkg::*; #(
  parameter bit HOST   = 1'b0,
  parameter int BLK_W  = 8,
  parameter int SYNC_N = 2,
  localparam int AW    = BLK_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          busy_i,
  input  logic [7:0]    rdata_i,
  output logic          sda_pull_o,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          wr_done_o,
  output logic          active_o
);
  logic scl_l, sda_l;
  logic scl_rise, scl_fall, start_c, stop_c;

  i2cm_sync #(.STAGES(SYNC_N)) u_sync_scl (.clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_l));
  i2cm_sync #(.STAGES(SYNC_N)) u_sync_sda (.clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_l));

  i2cm_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_l), .sda_i(sda_l),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  port_st_e      st;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic [7:0]    tx;
  logic [7:0]    ctrl_q;
  logic [AW-1:0] addr;
  logic          ack_go, rnw, m_ack, wrote;
  logic [7:0]    byte_in;
  logic          sel_ok, live, step, ack_ok;

  assign byte_in = {sh[6:0], sda_l};
  assign live    = (st != PS_IDLE) && (st != PS_SKIP);
  assign ack_ok  = ack_go && !busy_i;
  assign step    = live && scl_rise && (cnt == 4'd8) &&
                   ((st == PS_RD) || (st == PS_WR && sda_pull_o));

  generate
    if (HOST) begin : g_host_sel
      assign sel_ok = 1'b1;
    end else begin : g_disp_sel
      assign sel_ok = (byte_in[3:1] == 3'b000);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PS_IDLE; cnt <= '0; sh <= '0; tx <= '0; ctrl_q <= '0;
      addr <= '0; ack_go <= 1'b0; rnw <= 1'b0; m_ack <= 1'b0; wrote <= 1'b0;
      sda_pull_o <= 1'b0; we_o <= 1'b0; wdata_o <= '0; wr_done_o <= 1'b0;
    end else begin
      we_o      <= 1'b0;
      wr_done_o <= 1'b0;
      if (start_c) begin
        st <= PS_CTRL; cnt <= '0; ack_go <= 1'b0; sda_pull_o <= 1'b0;
      end else if (stop_c) begin
        st <= PS_IDLE; cnt <= '0; ack_go <= 1'b0; sda_pull_o <= 1'b0;
        wr_done_o <= wrote;
        wrote     <= 1'b0;
      end else if (live && scl_rise) begin
        if (cnt < 4'd8) begin
          sh  <= byte_in;
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            unique case (st)
              PS_CTRL: begin
                ctrl_q <= byte_in;
                ack_go <= (byte_in[7:4] == DEV_TYPE) && sel_ok;
                rnw    <= byte_in[0];
                addr[AW-1] <= HOST ? byte_in[1] : 1'b0;
              end
              PS_ADDR: begin
                ack_go <= 1'b1;
                addr[BLK_W-1:0] <= byte_in;
              end
              PS_WR:   ack_go <= 1'b1;
              default: ack_go <= 1'b0;
            endcase
          end
        end else if (cnt == 4'd8) begin
          cnt <= 4'd9;
          if (st == PS_RD) m_ack <= ~sda_l;
          if (step) addr <= {addr[AW-1], addr[BLK_W-1:0] + 1'b1};
        end
      end else if (live && scl_fall) begin
        if (cnt == 4'd8) begin
          if (st == PS_RD) begin
            sda_pull_o <= 1'b0;
          end else begin
            sda_pull_o <= ack_ok;
            if (!ack_ok) st <= PS_SKIP;
            if (st == PS_WR && ack_ok) begin
              we_o    <= 1'b1;
              wdata_o <= sh;
              wrote   <= 1'b1;
            end
          end
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          unique case (st)
            PS_CTRL: begin
              if (rnw) begin
                st <= PS_RD; tx <= {rdata_i[6:0], 1'b0}; sda_pull_o <= ~rdata_i[7];
              end else begin
                st <= PS_ADDR; sda_pull_o <= 1'b0;
              end
            end
            PS_ADDR: begin
              st <= PS_WR; sda_pull_o <= 1'b0;
            end
            PS_RD: begin
              if (m_ack) begin
                tx <= {rdata_i[6:0], 1'b0}; sda_pull_o <= ~rdata_i[7];
              end else begin
                st <= PS_SKIP; sda_pull_o <= 1'b0;
              end
            end
            default: sda_pull_o <= 1'b0;
          endcase
        end else if (st == PS_RD && cnt != 4'd0) begin
          sda_pull_o <= ~tx[7];
          tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  assign addr_o   = addr;
  assign active_o = (st != PS_IDLE);

  // R5: the pull only turns on while the clock line is low
  a_r5_pull_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_l);

  // R9: no acknowledge starts in a cycle that saw the programming cycle busy
  a_r9_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull_o) && $past(cnt) == 4'd8) |-> !$past(busy_i));

  // R2: leaving control reception towards a transfer requires the device code
  a_r2_code_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == PS_CTRL && (st == PS_ADDR || st == PS_RD)) |-> (ctrl_q[7:4] == DEV_TYPE));

  // R3: the display port only moves on with all-zero select bits
  a_r3_disp_select: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == PS_CTRL && (st == PS_ADDR || st == PS_RD)) |-> (HOST || ctrl_q[3:1] == 3'b000));

  // R6 / R7: address stepping never leaves its 256-byte block
  a_r6_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr[AW-1] == $past(addr[AW-1])));
endmodule

// File: rtl/dual_i2c_mem.sv
module dual_i2c_mem #(
  parameter int BLK_W       = 8,
  parameter int PROG_CYCLES = 5000,
  parameter int SYNC_N      = 2,
  localparam int AW         = BLK_W + 1,
  localparam int DEPTH      = 1 << AW,
  localparam int CW         = $clog2(PROG_CYCLES + 1),
  localparam int NPORT      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic disp_scl,
  input  logic disp_sda_in,
  output logic disp_sda_pull,
  input  logic host_scl,
  input  logic host_sda_in,
  output logic host_sda_pull,
  output logic prog_busy,
  output logic both_active
);
  logic [NPORT-1:0]   scl_v, sda_v, pull_v, we_v, done_v, act_v;
  logic [AW-1:0]      addr_v  [NPORT];
  logic [7:0]         wdata_v [NPORT];
  logic [7:0]         rdata_v [NPORT];
  logic [7:0]         mem [DEPTH];
  logic [CW-1:0]      pc;

  assign scl_v = {host_scl, disp_scl};
  assign sda_v = {host_sda_in, disp_sda_in};
  assign disp_sda_pull = pull_v[0];
  assign host_sda_pull = pull_v[1];

  genvar gi;
  generate
    for (gi = 0; gi < NPORT; gi++) begin : g_port
      assign rdata_v[gi] = mem[addr_v[gi]];
      i2cm_port #(.HOST(gi == 1), .BLK_W(BLK_W), .SYNC_N(SYNC_N)) u_port (
        .clk(clk), .rst_n(rst_n),
        .scl_i(scl_v[gi]), .sda_i(sda_v[gi]), .busy_i(prog_busy),
        .rdata_i(rdata_v[gi]), .sda_pull_o(pull_v[gi]),
        .addr_o(addr_v[gi]), .we_o(we_v[gi]), .wdata_o(wdata_v[gi]),
        .wr_done_o(done_v[gi]), .active_o(act_v[gi])
      );
    end
  endgenerate

  // host port wins a same-cycle write
  always_ff @(posedge clk) begin
    if (we_v[1])      mem[addr_v[1]] <= wdata_v[1];
    else if (we_v[0]) mem[addr_v[0]] <= wdata_v[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc <= '0;
    else if (|done_v)    pc <= CW'(PROG_CYCLES);
    else if (pc != '0)   pc <= pc - 1'b1;
  end

  assign prog_busy   = (pc != '0);
  assign both_active = &act_v;

  // R9: a programming cycle only begins right after a write transaction closes
  a_r9_busy_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_busy) |-> $past(|done_v));

  // R9: once running it continues until the counter drains
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(prog_busy) && $past(pc) > CW'(1)) |-> prog_busy);
endmodule

// File: tb/tb_dual_i2c_mem.sv
module tb_dual_i2c_mem;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int PROG       = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dscl = 1'b1, dsda_m = 1'b1, hscl = 1'b1, hsda_m = 1'b1;
  logic d_pull, h_pull, prog_busy, both_active;
  logic d_line, h_line;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  assign d_line = dsda_m & ~d_pull;
  assign h_line = hsda_m & ~h_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_i2c_mem #(.BLK_W(8), .PROG_CYCLES(PROG), .SYNC_N(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .disp_scl(dscl), .disp_sda_in(d_line), .disp_sda_pull(d_pull),
    .host_scl(hscl), .host_sda_in(h_line), .host_sda_pull(h_pull),
    .prog_busy(prog_busy), .both_active(both_active)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_scl(input int p, input logic v);
    if (p == 0) dscl = v; else hscl = v;
  endtask

  task automatic set_sda(input int p, input logic v);
    if (p == 0) dsda_m = v; else hsda_m = v;
  endtask

  function automatic logic line(input int p);
    return (p == 0) ? d_line : h_line;
  endfunction

  function automatic logic pull(input int p);
    return (p == 0) ? d_pull : h_pull;
  endfunction

  task automatic bus_start(input int p);
    set_sda(p, 1'b1); wq(Q);
    set_scl(p, 1'b1); wq(Q);
    set_sda(p, 1'b0); wq(Q);
    set_scl(p, 1'b0); wq(Q);
  endtask

  task automatic bus_stop(input int p);
    set_sda(p, 1'b0); wq(Q);
    set_scl(p, 1'b1); wq(Q);
    set_sda(p, 1'b1); wq(2*Q);
  endtask

  task automatic send_bit(input int p, input logic b);
    set_sda(p, b); wq(Q);
    set_scl(p, 1'b1); wq(2*Q);
    set_scl(p, 1'b0); wq(Q);
  endtask

  // returns 1 when the slave held the line low for the whole ninth high phase
  task automatic send_byte(input int p, input logic [7:0] b, input bit chk_rel,
                           output logic ack);
    logic a0, a1;
    for (int i = 7; i >= 0; i--) send_bit(p, b[i]);
    set_sda(p, 1'b1); wq(Q);
    set_scl(p, 1'b1); wq(1);
    a0 = ~line(p);
    wq(2*Q - 2);
    a1 = ~line(p);
    wq(1);
    set_scl(p, 1'b0); wq(Q);
    ack = a0 & a1;
    if (chk_rel && ack) chk("R5 release after ack clock", {31'd0, pull(p)}, 32'd0);
  endtask

  task automatic recv_byte(input int p, input bit mack, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      set_sda(p, 1'b1); wq(Q);
      set_scl(p, 1'b1); wq(Q);
      d = {d[6:0], line(p)};
      wq(Q);
      set_scl(p, 1'b0); wq(Q);
    end
    set_sda(p, ~mack); wq(Q);
    set_scl(p, 1'b1); wq(2*Q);
    set_scl(p, 1'b0); wq(Q);
    set_sda(p, 1'b1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (prog_busy && n < 4000) begin wq(1); n++; end
    chk("R9 programming cycle ends", {31'd0, prog_busy}, 32'd0);
  endtask

  // sets the word address through a write header, then reads n bytes
  task automatic rand_read(input int p, input logic [7:0] wctl, input logic [7:0] a,
                           input int n, input logic [7:0] exp0, input logic [7:0] exp1,
                           input logic [7:0] exp2, input string tag);
    logic ack;
    logic [7:0] d;
    logic [7:0] ex [3];
    ex[0] = exp0; ex[1] = exp1; ex[2] = exp2;
    bus_start(p);
    send_byte(p, wctl, 1'b1, ack); chk({tag, " ctrl ack"}, {31'd0, ack}, 32'd1);
    send_byte(p, a, 1'b0, ack);    chk({tag, " addr ack"}, {31'd0, ack}, 32'd1);
    bus_start(p);
    send_byte(p, wctl | 8'h01, 1'b0, ack); chk({tag, " read ctrl ack"}, {31'd0, ack}, 32'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(p, (i != n-1), d);
      chk({tag, " read data"}, {24'd0, d}, {24'd0, ex[i]});
    end
    bus_stop(p);
  endtask

  task automatic t_reset();
    chk("R9 reset busy", {31'd0, prog_busy}, 32'd0);
    chk("R10 reset both_active", {31'd0, both_active}, 32'd0);
    chk("R5 reset pulls", {30'd0, d_pull, h_pull}, 32'd0);
  endtask

  task automatic t_write_blocks();
    logic ack;
    bus_start(1);
    send_byte(1, 8'hA0, 1'b1, ack); chk("R2 host ctrl ack", {31'd0, ack}, 32'd1);
    send_byte(1, 8'hFE, 1'b1, ack); chk("R6 addr ack", {31'd0, ack}, 32'd1);
    send_byte(1, 8'h11, 1'b1, ack); chk("R5 data ack", {31'd0, ack}, 32'd1);
    send_byte(1, 8'h22, 1'b1, ack); chk("R6 data ack", {31'd0, ack}, 32'd1);
    send_byte(1, 8'h33, 1'b1, ack); chk("R6 wrap data ack", {31'd0, ack}, 32'd1);
    chk("R10 single port active", {31'd0, both_active}, 32'd0);
    bus_stop(1);
    wq(4);
    chk("R9 busy after write stop", {31'd0, prog_busy}, 32'd1);
    // while busy the display port refuses even a valid control byte
    bus_start(0);
    send_byte(0, 8'hA0, 1'b0, ack); chk("R9 no ack while busy", {31'd0, ack}, 32'd0);
    bus_stop(0);
    wait_idle();
    // block one through the host select bit
    bus_start(1);
    send_byte(1, 8'hA2, 1'b1, ack); chk("R4 block one ctrl ack", {31'd0, ack}, 32'd1);
    send_byte(1, 8'hFF, 1'b1, ack);
    send_byte(1, 8'hAA, 1'b1, ack);
    send_byte(1, 8'hBB, 1'b1, ack); chk("R6 block one wrap ack", {31'd0, ack}, 32'd1);
    bus_stop(1);
    wait_idle();
  endtask

  task automatic t_reads();
    rand_read(1, 8'hA0, 8'hFE, 3, 8'h11, 8'h22, 8'h33, "R7 host read with wrap");
    rand_read(1, 8'hA2, 8'h00, 1, 8'hBB, 8'h00, 8'h00, "R4 block one wrapped byte");
    rand_read(1, 8'hAE, 8'hFF, 1, 8'hAA, 8'h00, 8'h00, "R4 upper select ignored");
    rand_read(0, 8'hA0, 8'hFF, 2, 8'h22, 8'h33, 8'h00, "R3 display block zero");
  endtask

  task automatic t_nack_release();
    logic ack;
    logic [7:0] d;
    bus_start(1);
    send_byte(1, 8'hA0, 1'b1, ack);
    send_byte(1, 8'hFE, 1'b0, ack);
    bus_start(1);
    send_byte(1, 8'hA1, 1'b0, ack);
    recv_byte(1, 1'b0, d); chk("R8 last byte value", {24'd0, d}, 32'h11);
    chk("R8 released after no-ack", {31'd0, h_pull}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      set_sda(1, 1'b1); wq(Q); set_scl(1, 1'b1); wq(Q);
      chk("R8 line stays high", {31'd0, h_line}, 32'd1);
      wq(Q); set_scl(1, 1'b0); wq(Q);
    end
    bus_stop(1);
  endtask

  task automatic t_refusals();
    logic ack;
    bus_start(0);
    send_byte(0, 8'hA2, 1'b0, ack); chk("R3 display select 001 refused", {31'd0, ack}, 32'd0);
    bus_stop(0);
    bus_start(0);
    send_byte(0, 8'hA8, 1'b0, ack); chk("R3 display select 100 refused", {31'd0, ack}, 32'd0);
    bus_stop(0);
    bus_start(1);
    send_byte(1, 8'hB0, 1'b0, ack); chk("R2 wrong code refused", {31'd0, ack}, 32'd0);
    send_byte(1, 8'hA0, 1'b0, ack); chk("R2 ignored until start", {31'd0, ack}, 32'd0);
    bus_stop(1);
  endtask

  task automatic t_mid_restart();
    logic ack;
    bus_start(1);
    for (int i = 0; i < 4; i++) send_bit(1, 1'b1);
    bus_start(1);
    send_byte(1, 8'hA0, 1'b1, ack); chk("R1 restart mid byte", {31'd0, ack}, 32'd1);
    bus_stop(1);
    wq(4);
    chk("R1 stop ends transaction", {31'd0, both_active}, 32'd0);
  endtask

  task automatic t_both();
    fork
      rand_read(0, 8'hA0, 8'hFE, 2, 8'h11, 8'h22, 8'h00, "R10 display concurrent");
      rand_read(1, 8'hA2, 8'hFF, 2, 8'hAA, 8'hBB, 8'h00, "R10 host concurrent");
      begin
        wq(300);
        chk("R10 both active", {31'd0, both_active}, 32'd1);
      end
    join
    wq(4);
    chk("R10 both idle", {31'd0, both_active}, 32'd0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_write_blocks();
    t_reads();
    t_nack_release();
    t_refusals();
    t_mid_restart();
    t_both();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule